// File: doc/BRIEF.md
# E1 Multiframe Spare-Bit Collector and Inserter

This block deals with the spare and national bits carried in timeslot 0 of an E1 stream, taken over a whole 16-frame CRC4 multiframe. On the receive side, every spare-bit position is shifted into one of eight 8-bit fields as it arrives. The fields are the international bit of the align frames, the international bit of the non-align frames, the remote alarm bit, and the five national bits Sa4 to Sa8. When the multiframe strobe arrives, all eight fields are copied to host-visible registers in one cycle and a sticky receive flag is raised. The host then has one full multiframe to read them.

On the transmit side, the host writes eight matching registers. At each transmit multiframe strobe, their contents are copied into working shift registers and a sticky transmit flag is raised. During the next multiframe, the bits are sent MSB first into their timeslot 0 positions. A per-field enable register decides whether each field replaces the upstream bit or lets it pass. If the host writes nothing new, the same values are sent again.

The bit streams are described by a valid strobe, the bit index within timeslot 0 (0 is the first bit on the line), and the frame counter. Even frames are align frames and odd frames are non-align frames. Multiframe alignment and the CRC itself come from elsewhere.

Top module: `sa_mf_collector`

## Requirements
- R1: After reset the receive registers read 0x00, the transmit registers read 0xFF, the enable register reads 0x00, the status register reads 0x00, and `tx_bit_o` equals `tx_bit_i`.
- R2: A receive bit with index 0 goes to field 0 in even frames and to field 1 in odd frames. In odd frames, index 2 goes to field 2 (alarm) and indices 3 to 7 go to fields 3 to 7. Every other position is ignored. Bits shift in at the LSB, so the first bit of a multiframe ends up as the MSB.
- R3: Receive registers at addresses 0 to 7 change only on the cycle after `rx_mf_i`. All eight take the collected values at once, including a bit that is valid in the same cycle as the strobe.
- R4: Status bit 0 (address 17) and `rx_mf_flag_o` go high the cycle after `rx_mf_i` and stay high until the host writes 1 to bit 0 of address 17. A strobe in the same cycle as that write wins over the clear.
- R5: At `tx_mf_i`, the eight transmit registers are copied into working registers. For an enabled field, each valid bit position of that field outputs the next bit of its copy, MSB first.
- R6: Addresses 8 to 15 are read/write transmit registers for fields 0 to 7. A write affects only the copy taken at the next `tx_mf_i`. If the host does not write, the previous values are sent again.
- R7: Bit i of the enable register (address 16) selects field i. When that bit is clear, when no bit is valid, or at a position that belongs to no field, `tx_bit_o` equals `tx_bit_i`.
- R8: Status bit 1 and `tx_mf_flag_o` go high the cycle after `tx_mf_i`. They are cleared by writing 1 to bit 1 of address 17, and the strobe wins over a clear in the same cycle.
- R9: Writes to addresses 0 to 7, writes to status bits 2 to 7, and writes to addresses above 17 change nothing. Reads of addresses above 17 return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_bit_i | input | 1 | Received timeslot 0 bit |
| rx_vld_i | input | 1 | Receive bit valid |
| rx_pos_i | input | 3 | Bit index within timeslot 0 |
| rx_frm_i | input | 4 | Receive frame number within multiframe |
| rx_mf_i | input | 1 | Receive multiframe boundary strobe (frame 15) |
| tx_bit_i | input | 1 | Upstream transmit bit |
| tx_vld_i | input | 1 | Transmit bit valid |
| tx_pos_i | input | 3 | Transmit bit index within timeslot 0 |
| tx_frm_i | input | 4 | Transmit frame number within multiframe |
| tx_mf_i | input | 1 | Transmit multiframe boundary strobe (frame 15) |
| tx_bit_o | output | 1 | Transmit bit after insertion |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 5 | Register address |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data (combinational) |
| rx_mf_flag_o | output | 1 | Receive multiframe flag |
| tx_mf_flag_o | output | 1 | Transmit multiframe flag |

## Verification
The hardest cases to reach are the ones where a boundary coincides with other activity. One is a receive strobe in the same cycle as the last valid bit of frame 15. Another is a status clear arriving in the exact cycle a strobe sets the flag. The stimulus forces both on purpose in chosen multiframes. Transmit register writes are placed just after a boundary, and some multiframes skip them, so that retransmission of old values is seen. The enable pattern changes every multiframe, which makes passthrough and insertion alternate field by field.

// File: rtl/sa_mf_pkg.sv
package sa_mf_pkg;
  localparam int NFIELD = 8;
  localparam int FW     = 8;
  localparam int IDX_W  = $clog2(NFIELD);

  typedef enum logic [IDX_W-1:0] {
    F_SI_AF  = 3'd0,
    F_SI_NAF = 3'd1,
    F_RA     = 3'd2,
    F_SA4    = 3'd3,
    F_SA5    = 3'd4,
    F_SA6    = 3'd5,
    F_SA7    = 3'd6,
    F_SA8    = 3'd7
  } field_e;

  typedef struct packed {
    logic   hit;
    field_e idx;
  } fsel_t;

  // Map a timeslot 0 bit index to its spare-bit field.
  function automatic fsel_t decode_pos(input logic nalign, input logic [2:0] pos);
    fsel_t s;
    s.hit = 1'b0;
    s.idx = F_SI_AF;
    if (pos == 3'd0) begin
      s.hit = 1'b1;
      s.idx = nalign ? F_SI_NAF : F_SI_AF;
    end else if (nalign && pos == 3'd2) begin
      s.hit = 1'b1;
      s.idx = F_RA;
    end else if (nalign && pos >= 3'd3) begin
      s.hit = 1'b1;
      s.idx = field_e'(pos);
    end
    return s;
  endfunction
endpackage

// File: rtl/sa_rx_collect.sv
module sa_rx_collect
  import sa_mf_pkg::*;
(
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      vld_i,
  input  logic                      bit_i,
  input  logic                      nalign_i,
  input  logic [2:0]                pos_i,
  input  logic                      mf_i,
  output logic [NFIELD-1:0][FW-1:0] vis_o
);
  fsel_t                     sel;
  logic [NFIELD-1:0][FW-1:0] sh_q, sh_d;

  assign sel = decode_pos(nalign_i, pos_i);

  for (genvar g = 0; g < NFIELD; g++) begin : g_fld
    assign sh_d[g] = (vld_i && sel.hit && sel.idx == field_e'(g))
                   ? {sh_q[g][FW-2:0], bit_i} : sh_q[g];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q  <= '0;
      vis_o <= '0;
    end else begin
      sh_q <= sh_d;
      if (mf_i) vis_o <= sh_d;
    end
  end

  assert_rx_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mf_i |=> $stable(vis_o));
  assert_rx_idle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vld_i |=> $stable(sh_q));
endmodule

// File: rtl/sa_tx_insert.sv
module sa_tx_insert
  import sa_mf_pkg::*;
(
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      vld_i,
  input  logic                      bit_i,
  input  logic                      nalign_i,
  input  logic [2:0]                pos_i,
  input  logic                      mf_i,
  input  logic [NFIELD-1:0][FW-1:0] host_i,
  input  logic [NFIELD-1:0]         ena_i,
  output logic                      bit_o
);
  fsel_t                     sel;
  logic [NFIELD-1:0][FW-1:0] work_q;

  assign sel = decode_pos(nalign_i, pos_i);

  for (genvar g = 0; g < NFIELD; g++) begin : g_fld
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        work_q[g] <= '1;
      else if (mf_i)
        work_q[g] <= host_i[g];
      else if (vld_i && sel.hit && sel.idx == field_e'(g))
        work_q[g] <= {work_q[g][FW-2:0], 1'b0};
    end
  end

  always_comb begin
    bit_o = bit_i;
    if (vld_i && sel.hit && ena_i[sel.idx]) bit_o = work_q[sel.idx][FW-1];
  end

  assert_tx_pass_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vld_i |-> bit_o == bit_i);
  assert_tx_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mf_i && !vld_i) |=> $stable(work_q));
endmodule

// File: rtl/sa_host_regs.sv
module sa_host_regs
  import sa_mf_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      we_i,
  input  logic [ADDR_W-1:0]         addr_i,
  input  logic [FW-1:0]             wdata_i,
  input  logic [NFIELD-1:0][FW-1:0] rx_vis_i,
  input  logic                      rx_mf_i,
  input  logic                      tx_mf_i,
  output logic [FW-1:0]             rdata_o,
  output logic [NFIELD-1:0][FW-1:0] tx_host_o,
  output logic [NFIELD-1:0]         ena_o,
  output logic                      rx_flag_o,
  output logic                      tx_flag_o
);
  localparam int A_TX   = NFIELD;
  localparam int A_CTRL = 2 * NFIELD;
  localparam int A_STAT = 2 * NFIELD + 1;

  logic in_rx, in_tx, clr_rx, clr_tx;
  logic [IDX_W-1:0] sub;

  assign sub    = addr_i[IDX_W-1:0];
  assign in_rx  = addr_i < ADDR_W'(A_TX);
  assign in_tx  = !in_rx && addr_i < ADDR_W'(A_CTRL);
  assign clr_rx = we_i && addr_i == ADDR_W'(A_STAT) && wdata_i[0];
  assign clr_tx = we_i && addr_i == ADDR_W'(A_STAT) && wdata_i[1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_host_o <= '1;
      ena_o     <= '0;
      rx_flag_o <= 1'b0;
      tx_flag_o <= 1'b0;
    end else begin
      if (we_i && in_tx) tx_host_o[sub] <= wdata_i;
      if (we_i && addr_i == ADDR_W'(A_CTRL)) ena_o <= wdata_i[NFIELD-1:0];
      if (rx_mf_i)     rx_flag_o <= 1'b1;
      else if (clr_rx) rx_flag_o <= 1'b0;
      if (tx_mf_i)     tx_flag_o <= 1'b1;
      else if (clr_tx) tx_flag_o <= 1'b0;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (in_rx)                           rdata_o = rx_vis_i[sub];
    else if (in_tx)                      rdata_o = tx_host_o[sub];
    else if (addr_i == ADDR_W'(A_CTRL))  rdata_o = FW'(ena_o);
    else if (addr_i == ADDR_W'(A_STAT))  rdata_o = FW'({tx_flag_o, rx_flag_o});
  end

  assert_rx_flag_set_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_mf_i |=> rx_flag_o);
  assert_tx_flag_set_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_mf_i |=> tx_flag_o);
  assert_rx_flag_sticky_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_flag_o && !clr_rx) |=> rx_flag_o);
  assert_tx_flag_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_flag_o && !clr_tx) |=> tx_flag_o);
endmodule

// File: rtl/sa_mf_collector.sv
module sa_mf_collector
  import sa_mf_pkg::*;
#(
  parameter int FRAMES = 16,
  parameter int ADDR_W = 5,
  localparam int FRM_W = $clog2(FRAMES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rx_bit_i,
  input  logic              rx_vld_i,
  input  logic [2:0]        rx_pos_i,
  input  logic [FRM_W-1:0]  rx_frm_i,
  input  logic              rx_mf_i,
  input  logic              tx_bit_i,
  input  logic              tx_vld_i,
  input  logic [2:0]        tx_pos_i,
  input  logic [FRM_W-1:0]  tx_frm_i,
  input  logic              tx_mf_i,
  output logic              tx_bit_o,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [FW-1:0]     reg_wdata_i,
  output logic [FW-1:0]     reg_rdata_o,
  output logic              rx_mf_flag_o,
  output logic              tx_mf_flag_o
);
  logic [NFIELD-1:0][FW-1:0] rx_vis, tx_host;
  logic [NFIELD-1:0]         ena;

  sa_rx_collect u_rx (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .vld_i    (rx_vld_i),
    .bit_i    (rx_bit_i),
    .nalign_i (rx_frm_i[0]),
    .pos_i    (rx_pos_i),
    .mf_i     (rx_mf_i),
    .vis_o    (rx_vis)
  );

  sa_tx_insert u_tx (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .vld_i    (tx_vld_i),
    .bit_i    (tx_bit_i),
    .nalign_i (tx_frm_i[0]),
    .pos_i    (tx_pos_i),
    .mf_i     (tx_mf_i),
    .host_i   (tx_host),
    .ena_i    (ena),
    .bit_o    (tx_bit_o)
  );

  sa_host_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (reg_we_i),
    .addr_i    (reg_addr_i),
    .wdata_i   (reg_wdata_i),
    .rx_vis_i  (rx_vis),
    .rx_mf_i   (rx_mf_i),
    .tx_mf_i   (tx_mf_i),
    .rdata_o   (reg_rdata_o),
    .tx_host_o (tx_host),
    .ena_o     (ena),
    .rx_flag_o (rx_mf_flag_o),
    .tx_flag_o (tx_mf_flag_o)
  );

  // Boundary strobes belong to the last frame of the multiframe.
  assert_rx_mf_frame_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_mf_i |-> rx_frm_i == FRM_W'(FRAMES - 1));
  assert_tx_mf_frame_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_mf_i |-> tx_frm_i == FRM_W'(FRAMES - 1));
endmodule

// File: tb/sim_sa_mf_collector.sv
`timescale 1ns/1ps
module sim_sa_mf_collector;
  logic clk = 1'b0, rst_n = 1'b0;
  logic rx_bit = 0, rx_vld = 0, rx_mf = 0, tx_bit = 0, tx_vld = 0, tx_mf = 0, we = 0;
  logic [2:0] rx_pos = 0, tx_pos = 0;
  logic [3:0] rx_frm = 0, tx_frm = 0;
  logic [4:0] addr = 0;
  logic [7:0] wdata = 0, rdata;
  logic tx_out, rflag_o, tflag_o;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  int unsigned seed = 32'h1234_5678;

  // reference model state
  int rsh[8], rvis[8], thost[8], twork[8];
  int ctrl = 0, rflag = 0, tflag = 0;

  always #10 clk = ~clk;

  sa_mf_collector u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .rx_bit_i(rx_bit), .rx_vld_i(rx_vld), .rx_pos_i(rx_pos), .rx_frm_i(rx_frm), .rx_mf_i(rx_mf),
    .tx_bit_i(tx_bit), .tx_vld_i(tx_vld), .tx_pos_i(tx_pos), .tx_frm_i(tx_frm), .tx_mf_i(tx_mf),
    .tx_bit_o(tx_out),
    .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .rx_mf_flag_o(rflag_o), .tx_mf_flag_o(tflag_o)
  );

  function automatic int fld(int frm, int pos);
    if (pos == 0) return frm % 2;
    if (frm % 2 == 0 || pos == 1) return -1;
    return pos;
  endfunction

  function automatic int model_rd(int a);
    if (a < 8) return rvis[a];
    if (a < 16) return thost[a-8];
    if (a == 16) return ctrl;
    if (a == 17) return tflag * 2 + rflag;
    return 0;
  endfunction

  function automatic string rd_tag(int a);
    if (a < 8) return "R2,R3,R9";
    if (a < 16) return "R6";
    if (a == 16) return "R7";
    if (a == 17) return "R4,R8";
    return "R9";
  endfunction

  function automatic int rnd();
    seed = seed * 1103515245 + 12345;
    return int'(seed >> 16) & 32'h7fff;
  endfunction

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  // model update
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 8; i++) begin rsh[i] = 0; rvis[i] = 0; thost[i] = 255; twork[i] = 255; end
      ctrl = 0; rflag = 0; tflag = 0;
    end else begin
      int f;
      f = fld(int'(rx_frm), int'(rx_pos));
      if (rx_vld && f >= 0) rsh[f] = ((rsh[f] << 1) | int'(rx_bit)) & 255;
      if (rx_mf) for (int i = 0; i < 8; i++) rvis[i] = rsh[i];
      f = fld(int'(tx_frm), int'(tx_pos));
      if (tx_mf) for (int i = 0; i < 8; i++) twork[i] = thost[i];
      else if (tx_vld && f >= 0) twork[f] = (twork[f] << 1) & 255;
      if (we && addr >= 8 && addr < 16) thost[addr-8] = int'(wdata);
      if (we && addr == 16) ctrl = int'(wdata);
      if (we && addr == 17 && wdata[0]) rflag = 0;
      if (we && addr == 17 && wdata[1]) tflag = 0;
      if (rx_mf) rflag = 1;
      if (tx_mf) tflag = 1;
    end
  end

  // per-cycle comparison
  always @(negedge clk) begin
    if (rst_n && !done) begin
      int f, exp_bit;
      chk(rd_tag(int'(addr)), int'(rdata), model_rd(int'(addr)));
      f = fld(int'(tx_frm), int'(tx_pos));
      exp_bit = int'(tx_bit);
      if (tx_vld && f >= 0 && ctrl[f]) exp_bit = (twork[f] >> 7) & 1;
      chk((tx_vld && f >= 0 && ctrl[f]) ? "R5" : "R7", int'(tx_out), exp_bit);
      chk("R4", int'(rflag_o), rflag);
      chk("R8", int'(tflag_o), tflag);
    end
  end

  task automatic step();
    @(posedge clk); #2;
  endtask

  task automatic run_mf(bit upd, int ctrl_val, bit clr, bit coinc, bit clr_at_mf);
    for (int fr = 0; fr < 16; fr++) begin
      for (int p = 0; p < 8; p++) begin
        int idx;
        idx = fr * 8 + p;
        step();
        rx_vld = 1; rx_bit = rnd() % 2; rx_pos = 3'(p); rx_frm = 4'(fr);
        tx_vld = 1; tx_bit = rnd() % 2; tx_pos = 3'(p); tx_frm = 4'(fr);
        rx_mf = coinc && fr == 15 && p == 7;
        we = 1;
        if (idx < 8 && upd) begin addr = 5'(8 + idx); wdata = 8'(rnd()); end
        else if (idx == 8) begin addr = 5'd16; wdata = 8'(ctrl_val); end
        else if (idx == 9 && clr) begin addr = 5'd17; wdata = 8'hFF; end
        else if (idx == 10) begin addr = 5'(idx % 8); wdata = 8'(rnd()); end  // R9
        else if (idx == 11) begin addr = 5'd25; wdata = 8'hA5; end             // R9
        else begin we = 0; addr = 5'(idx % 24); end
        step();
        rx_vld = 0; tx_vld = 0; rx_mf = 0; we = 0;
        addr = 5'((idx + 5) % 24);
      end
    end
    step();
    rx_frm = 4'd15; tx_frm = 4'd15;
    rx_mf = !coinc; tx_mf = 1;
    if (clr_at_mf) begin we = 1; addr = 5'd17; wdata = 8'h03; end  // R4 R8 set wins
    step();
    rx_mf = 0; tx_mf = 0; we = 0; addr = 5'd17;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    // R1: reset values
    for (int a = 0; a < 18; a++) begin
      step();
      addr = 5'(a);
      @(negedge clk);
      chk("R1", int'(rdata), (a >= 8 && a < 16) ? 255 : 0);
      chk("R1", int'(tx_out), int'(tx_bit));
    end
    run_mf(1, 8'h00, 0, 0, 0);
    run_mf(0, 8'hFF, 0, 0, 0);
    run_mf(1, 8'hA5, 1, 1, 0);
    run_mf(1, 8'h5A, 0, 0, 1);
    run_mf(0, 8'hFF, 1, 1, 0);
    run_mf(1, 8'h3C, 1, 0, 0);
    for (int a = 0; a < 24; a++) begin step(); addr = 5'(a); end
    step();
    @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule